// File: doc/BRIEF.md
# SPI Paired-Word Register Write Decoder

This block turns a stream of 32-bit words from an SPI slave into register write commands. Words come in pairs. The first word of a pair holds a 2-bit command code in bits 31:30 and a 30-bit byte address in bits 29:0. The second word is the data. When a pair completes with a valid write, the block stores the word-aligned address and the data as one entry in a command queue. A consumer drains that queue and sees the entry's address already split into a 1 MB bank index and a byte offset within the bank.

During every word exchange, the SPI shifter sends a 32-bit status word back to the host. From that word the host can tell which half of a pair the block expects next and how many commands are still waiting. The host can also resynchronise by releasing slave select. A write to address zero of bank 0 is a poll: it only lets the host read a fresh status word and stores nothing.

Top module: `spi_pair_decoder`

## Requirements
- R1: After reset, the phase bit is 0, the queue is empty (`q_valid_o` = 0, status bits 30:24 = 0) and `overflow_o` = 0.
- R2: Status bit 31 is the phase. It is 0 while an address word is expected and 1 while a data word is expected. It toggles on every word accepted with slave select active.
- R3: A pair with command code 2'b00 and a word address (bits 29:2) that is not zero pushes one entry. The entry is the address with bits 1:0 forced to 0, plus the data word. The fill level rises by one.
- R4: A write whose address bits 29:2 are all zero is a poll. It pushes nothing, whatever the data and whatever the byte offset in bits 1:0.
- R5: A pair whose command code is 2'b01, 2'b10 or 2'b11 is discarded without a push, and the phase still returns to 0.
- R6: While `ss_active_i` is 0, the phase is forced to 0 and a partial pair is discarded. The next word is taken as an address word.
- R7: The status word carries the queue fill level in bits 30:24. Bits 23:8 mirror `ext_status_i`. Bits 7:4 hold `PLATFORM_ID` and bits 3:0 hold `VERSION`.
- R8: For the head entry, `q_bank_o` is address bits 29:20 and `q_offset_o` is address bits 19:0. Bank 0 covers 0x000000, bank 1 covers 0x100000 and bank 2 covers 0x200000.
- R9: Entries leave in push order. `pop_i` with a non-empty queue removes the head. `q_valid_o` is 1 exactly when the fill level is not zero.
- R10: The queue holds `DEPTH` entries (default 64). A push into a full queue with no pop in the same cycle is dropped and sets `overflow_o`. That flag stays set until reset.
- R11: A push and a pop in the same cycle leave the fill level unchanged. This holds even when the queue is full, and in that case no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ss_active_i | input | 1 | Slave select active (1 = selected) |
| word_valid_i | input | 1 | One-cycle strobe: a full 32-bit word has arrived |
| word_i | input | 32 | Received word |
| ext_status_i | input | 16 | Link and sample-path status placed in status bits 23:8 |
| status_o | output | 32 | Status word for the SPI shifter to send |
| pop_i | input | 1 | Consumer removes the head entry |
| q_valid_o | output | 1 | Queue holds at least one entry |
| q_bank_o | output | 10 | Bank index of the head entry |
| q_offset_o | output | 20 | Byte offset in the bank of the head entry |
| q_data_o | output | 32 | Data of the head entry |
| overflow_o | output | 1 | Sticky flag: a push was dropped |

## Verification
The interaction that matters most is a completing data word arriving in the same cycle as a consumer pop. Then the push and the pop both act on the fill counter and on the storage at once. The bench provokes this twice: once with a part-filled queue and once with a full queue. The pop is raised in the same cycle as the data word strobe. The bench then judges the fill field of the status word, `overflow_o`, and the later drain order against a queue model kept in the bench. A second collision, slave select dropping while a pair is half complete, is judged by the phase bit and by the address of the next entry pushed.

// File: rtl/spi_pair_pkg.sv
package spi_pair_pkg;
  localparam int ADDR_W    = 30;
  localparam int DATA_W    = 32;
  localparam int BANK_LSB  = 20;
  localparam int BANK_W    = ADDR_W - BANK_LSB;
  localparam int FILL_W    = 7;
  localparam int EXT_W     = 16;
  localparam logic [1:0] CMD_WRITE = 2'b00;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_entry_t;
endpackage

// File: rtl/spi_pair_track.sv
module spi_pair_track
  import spi_pair_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ss_active_i,
  input  logic        word_valid_i,
  input  logic [31:0] word_i,
  output logic        phase_o,
  output logic        push_o,
  output wr_entry_t   entry_o
);
  logic              phase_q;
  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              word_ok, is_write, is_poll;

  assign word_ok = word_valid_i & ss_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cmd_q   <= 2'b11;
      addr_q  <= '0;
    end else if (!ss_active_i) begin
      phase_q <= 1'b0;
    end else if (word_ok) begin
      phase_q <= ~phase_q;
      if (!phase_q) begin
        cmd_q  <= word_i[31:30];
        addr_q <= word_i[ADDR_W-1:0];
      end
    end
  end

  assign is_write = (cmd_q == CMD_WRITE);
  // word granularity: byte lanes inside word 0 still count as the poll address
  assign is_poll  = (addr_q[ADDR_W-1:2] == '0);

  assign push_o  = word_ok & phase_q & is_write & ~is_poll;
  assign phase_o = phase_q;
  assign entry_o = '{addr: {addr_q[ADDR_W-1:2], 2'b00}, data: word_i};

  a_r6_ss_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_active_i |=> !phase_q);
  a_r2_phase_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ok |=> (phase_q != $past(phase_q)));
  a_r2_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_i && !word_valid_i) |=> $stable(phase_q));
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue
  import spi_pair_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wr_entry_t        entry_i,
  input  logic             pop_i,
  output wr_entry_t        head_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  wr_entry_t        mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign pop_ok  = pop_i & ~empty;
  // a same-cycle pop frees the slot the push needs
  assign push_ok = push_i & (~full | pop_ok);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
      if (push_i && !push_ok) ovf_q <= 1'b1;
    end
  end

  assign head_o     = mem_q[rd_ptr_q];
  assign valid_o    = ~empty;
  assign count_o    = count_q;
  assign overflow_o = ovf_q;

  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full) |=> (ovf_q && count_q == CNT_W'(DEPTH)));
  a_r11_push_pop_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty) |=> $stable(count_q));
  a_r9_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> (count_q == '0));
endmodule

// File: rtl/status_pack.sv
module status_pack
  import spi_pair_pkg::*;
#(
  parameter int         CNT_W       = 7,
  parameter logic [3:0] PLATFORM_ID = 4'h3,
  parameter logic [3:0] VERSION     = 4'h2
) (
  input  logic             phase_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic [31:0]      status_o
);
  logic [FILL_W-1:0] fill;

  generate
    if (CNT_W > FILL_W) begin : g_sat
      assign fill = (count_i > CNT_W'({FILL_W{1'b1}})) ? {FILL_W{1'b1}}
                                                        : count_i[FILL_W-1:0];
    end else begin : g_ext
      assign fill = FILL_W'(count_i);
    end
  endgenerate

  assign status_o = {phase_i, fill, ext_i, PLATFORM_ID, VERSION};
endmodule

// File: rtl/spi_pair_decoder.sv
module spi_pair_decoder
  import spi_pair_pkg::*;
#(
  parameter int         DEPTH       = 64,
  parameter logic [3:0] PLATFORM_ID = 4'h3,
  parameter logic [3:0] VERSION     = 4'h2,
  localparam int        CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ss_active_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  input  logic [EXT_W-1:0]  ext_status_i,
  output logic [31:0]       status_o,
  input  logic              pop_i,
  output logic              q_valid_o,
  output logic [BANK_W-1:0] q_bank_o,
  output logic [BANK_LSB-1:0] q_offset_o,
  output logic [DATA_W-1:0] q_data_o,
  output logic              overflow_o
);
  logic             phase, push;
  wr_entry_t        entry, head;
  logic [CNT_W-1:0] count;

  spi_pair_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ss_active_i  (ss_active_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .phase_o      (phase),
    .push_o       (push),
    .entry_o      (entry)
  );

  cmd_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .entry_i    (entry),
    .pop_i      (pop_i),
    .head_o     (head),
    .valid_o    (q_valid_o),
    .count_o    (count),
    .overflow_o (overflow_o)
  );

  status_pack #(.CNT_W(CNT_W), .PLATFORM_ID(PLATFORM_ID), .VERSION(VERSION)) u_status (
    .phase_i  (phase),
    .count_i  (count),
    .ext_i    (ext_status_i),
    .status_o (status_o)
  );

  assign q_bank_o   = head.addr[ADDR_W-1:BANK_LSB];
  assign q_offset_o = head.addr[BANK_LSB-1:0];
  assign q_data_o   = head.data;

  a_r3_aligned_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> (q_offset_o[1:0] == 2'b00));
  a_r4_no_poll_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> ({q_bank_o, q_offset_o[BANK_LSB-1:2]} != '0));
endmodule

// File: tb/spi_pair_decoder_test.sv
module spi_pair_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam logic [3:0] PID = 4'h3;
  localparam logic [3:0] VER = 4'h2;

  logic        clk = 0, rst_ni = 0;
  logic        ss = 0, wv = 0, pop = 0;
  logic [31:0] word = '0;
  logic [15:0] ext = 16'hA5C3;
  logic [31:0] status;
  logic        q_valid, ovf;
  logic [9:0]  q_bank;
  logic [19:0] q_off;
  logic [31:0] q_data;

  int n_chk = 0, n_fail = 0;
  logic [61:0] mq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pair_decoder #(.DEPTH(DEPTH), .PLATFORM_ID(PID), .VERSION(VER)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ss_active_i(ss), .word_valid_i(wv),
    .word_i(word), .ext_status_i(ext), .status_o(status), .pop_i(pop),
    .q_valid_o(q_valid), .q_bank_o(q_bank), .q_offset_o(q_off),
    .q_data_o(q_data), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // starts and ends at a falling edge
  task automatic send_word(input logic [31:0] w);
    wv = 1; word = w;
    @(negedge clk);
    wv = 0;
  endtask

  function automatic bit expect_push(input logic [31:0] aw);
    return (aw[31:30] == 2'b00) && (aw[29:2] != '0);
  endfunction

  task automatic send_pair(input logic [31:0] aw, input logic [31:0] dw, input string req);
    send_word(aw);
    check(status[31] == 1'b1, "R2 phase after address", status[31], 1);
    send_word(dw);
    check(status[31] == 1'b0, "R2 phase after data", status[31], 0);
    if (expect_push(aw)) begin
      if (mq.size() < DEPTH) mq.push_back({aw[29:2], 2'b00, dw});
    end
    check(status[30:24] == 7'(mq.size()), req, status[30:24], mq.size());
  endtask

  task automatic pop_check(input string req);
    logic [61:0] e;
    e = mq.pop_front();
    check(q_valid == 1'b1, "R9 valid before pop", q_valid, 1);
    check({q_bank, q_off, q_data} == e, req, {q_bank, q_off, q_data}, e);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status == {1'b0, 7'd0, ext, PID, VER}, "R1 reset status", status, {1'b0, 7'd0, ext, PID, VER});
    check(q_valid == 1'b0, "R1 reset q_valid", q_valid, 0);
    check(ovf == 1'b0, "R1 reset overflow", ovf, 0);
    rst_ni = 1; ss = 1;
    @(negedge clk);

    // sweep command codes x addresses (R3 R4 R5)
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 8; i++) begin
        logic [29:0] a;
        a = 30'((i % 3) << 20) | 30'(i * 4) | 30'(i % 4);
        send_pair({2'(c), a}, 32'hC0DE0000 ^ 32'((c << 8) | i),
                  (c == 0) ? (((a >> 2) == 0) ? "R4 poll fill" : "R3 push fill") : "R5 reserved cmd fill");
      end
    end
    // explicit poll with a byte offset inside word 0 (R4)
    send_pair(32'h0000_0003, 32'hFFFF_FFFF, "R4 poll byte offset");
    check(status[30:24] == 7'd7, "R3 seven pushes", status[30:24], 7);

    // R7 status fields
    ext = 16'h1234;
    #1;
    check(status[23:0] == {16'h1234, PID, VER}, "R7 status fields", status[23:0], {16'h1234, PID, VER});

    // drain (R8 R9)
    while (mq.size() > 0) pop_check("R8 bank/offset/data head");
    check(q_valid == 1'b0, "R9 empty after drain", q_valid, 0);
    // pop on empty has no effect
    pop = 1; @(negedge clk); pop = 0;
    check(status[30:24] == 7'd0, "R9 pop when empty", status[30:24], 0);

    // R6 slave select abort
    send_word(32'h0010_0040);
    check(status[31] == 1'b1, "R6 mid pair", status[31], 1);
    ss = 0; @(negedge clk); ss = 1;
    check(status[31] == 1'b0, "R6 phase reset", status[31], 0);
    send_pair(32'h0020_0084, 32'h5555_AAAA, "R6 fresh pair fill");
    check({q_bank, q_off} == {10'd2, 20'h00084}, "R6 new address taken", {q_bank, q_off}, {10'd2, 20'h00084});

    // R11 same-cycle push/pop, part filled
    send_pair(32'h0010_0100, 32'h1111_0001, "R3 push fill");
    send_word(32'h0010_0104);
    check({q_bank, q_off, q_data} == mq[0], "R11 head before", {q_bank, q_off, q_data}, mq[0]);
    void'(mq.pop_front());
    mq.push_back({28'h0010_0104 >> 2, 2'b00, 32'h2222_0002});
    wv = 1; word = 32'h2222_0002; pop = 1;
    @(negedge clk);
    wv = 0; pop = 0;
    check(status[30:24] == 7'd2, "R11 fill unchanged", status[30:24], 2);
    while (mq.size() > 0) pop_check("R9 order after push/pop");

    // fill to DEPTH
    for (int i = 0; i < DEPTH; i++)
      send_pair(32'h0010_0000 | 32'((i + 1) * 4), 32'(i) ^ 32'hBEEF_0000, "R3 fill up");
    check(status[30:24] == 7'(DEPTH), "R10 full level", status[30:24], DEPTH);

    // R11 at full: push with pop, no overflow
    send_word(32'h0010_0FF0);
    void'(mq.pop_front());
    mq.push_back({28'h0010_0FF0 >> 2, 2'b00, 32'h7777_7777});
    wv = 1; word = 32'h7777_7777; pop = 1;
    @(negedge clk);
    wv = 0; pop = 0;
    check(status[30:24] == 7'(DEPTH), "R11 full push/pop level", status[30:24], DEPTH);
    check(ovf == 1'b0, "R11 no overflow", ovf, 0);

    // R10 overflow drop
    send_pair(32'h0010_0FF4, 32'hDEAD_DEAD, "R10 dropped fill");
    check(ovf == 1'b1, "R10 overflow set", ovf, 1);
    while (mq.size() > 0) pop_check("R10 order, dropped entry absent");
    check(q_valid == 1'b0, "R10 drained", q_valid, 0);
    check(ovf == 1'b1, "R10 overflow sticky", ovf, 1);

    report();
  end
endmodule